// File: doc/BRIEF.md
# Multi-Domain Time-of-Day Counter

This block keeps several independent time-of-day clocks, one per timing domain, for a packet-timing subsystem. Every domain holds a seconds count and a nanoseconds count. When its enable bit is set, a domain advances on each core clock by a programmable period. That period is a fixed-point nanosecond value whose fractional part builds up in an accumulator until it carries into the nanoseconds. The nanoseconds roll over into the seconds at one billion.

A register-style access port manages the domains. It holds a nanosecond word and a seconds value, and it carries an action code and a domain select. A change of the action code fires exactly one operation on the selected domain. The operation copies the domain time into the access registers, loads new time from them, or adds a signed nanosecond offset. A small negative result is kept in a wrapped nanosecond form, and readers decode that form as one second less.

The period of each domain can only be rewritten under a freeze bit. New values take effect when that bit is released, so the rate never changes partway through a multi-word update.

Top module: `tod_multi_domain`

## Requirements
- R1: After reset, every domain reads 0 seconds and 0 ns, both access registers read 0, every period equals the nominal value 0x1FF0000000000000 (3.9921875 ns), and the action history is IDLE.
- R2: An enabled domain gains its period every clock: bits 63..59 are whole nanoseconds and bits 58..0 are a fraction. Fraction overflow adds one nanosecond, so after N clocks at the nominal period from a zero fraction the count reads floor(N*511/128).
- R3: A domain whose enable bit is 0 holds its time unless an action targets it.
- R4: When an increment reaches 1,000,000,000 ns or more, the nanoseconds drop by 1,000,000,000 and the seconds rise by one in the same clock.
- R5: The action codes are IDLE=0, LOAD=1, SAVE=2, CLOCK=3, DELTA=4 and TOD=5. LOAD fires only when the code changes from IDLE to 1. At that edge the selected domain takes the access seconds and ns[29:0] and clears its fraction, with no increment in that clock. A switch to LOAD from any other code is ignored.
- R6: SAVE fires when the code changes to 2. At that edge it copies the selected domain's seconds and nanoseconds, as they stood just before the edge, into the access registers in one cycle (nanoseconds zero-extended to 32 bits).
- R7: DELTA fires when the code changes to 4. It adds the access nanosecond word, read as a signed 32-bit value, to the selected domain, with a carry or borrow into the seconds. A value of magnitude 500,000,000 or more is ignored, and the domain does not increment in a clock where a delta is applied.
- R8: A result from -16 to -1 ns is kept as 2^30 plus that value (0x3FFFFFF0..0x3FFFFFFF) with the seconds unchanged. A result below -16 adds 1,000,000,000 and takes one second off. Counting from the wrapped form passes through zero without touching the seconds.
- R9: An action fires once per change of the code. Holding a code does nothing further. Codes 3 and 5, and a domain select of NUM_DOM or above, change neither the domains nor the access registers.
- R10: Period writes always go to a shadow register. The active period copies the shadow on the edge where that domain's freeze bit goes from 1 to 0, so a write while the freeze bit is low leaves the rate unchanged.
- R11: An access write with select 0 sets the 32-bit nanosecond word, select 1 sets seconds bits 31..0, and select 2 sets seconds bits 47..32 from data bits 15..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dom_ena_i | input | NUM_DOM | Per-domain count enable |
| per_frz_i | input | NUM_DOM | Per-domain period freeze; falling edge commits shadow period |
| per_wr_i | input | 1 | Period shadow write strobe |
| per_dom_i | input | DOM_W | Domain targeted by the period write |
| per_wdata_i | input | PER_W | Period value, 59 fraction bits |
| acc_act_i | input | 3 | Action code |
| acc_dom_i | input | DOM_W | Domain targeted by the action |
| acc_wr_i | input | 1 | Access register write strobe |
| acc_wsel_i | input | 2 | Access word select (0 ns, 1 sec low, 2 sec high) |
| acc_wdata_i | input | 32 | Access write data |
| acc_sec_o | output | SEC_W | Access seconds register |
| acc_ns_o | output | 32 | Access nanosecond word |
| tod_sec_o | output | NUM_DOM*SEC_W | Seconds of all domains, domain d at bits d*SEC_W |
| tod_ns_o | output | NUM_DOM*NS_W | Nanoseconds of all domains, domain d at bits d*NS_W |

## Verification
Every result becomes visible one clock edge after the stimulus that causes it. An action code, an access write or an enable change is driven just after a falling edge. The next rising edge applies it, and the outputs are sampled at the falling edge that follows. The freeze release counts as a stimulus at that same edge, so the new rate appears from the second edge on, and the checks count edges from the release. For SAVE, the expected snapshot is the domain time sampled in the same half-cycle in which the code is driven, which is the value just before the firing edge.

// File: rtl/tod_pkg.sv
// Shared types and constants for the multi-domain time-of-day counter.
// Assumes nanoseconds fit in 30 bits and the access word is 32 bits wide.
package tod_pkg;

    typedef enum logic [2:0] {
        ACT_IDLE  = 3'd0,
        ACT_LOAD  = 3'd1,
        ACT_SAVE  = 3'd2,
        ACT_CLOCK = 3'd3,
        ACT_DELTA = 3'd4,
        ACT_TOD   = 3'd5
    } tod_act_e;

    localparam int          NS_PER_SEC   = 1_000_000_000;
    localparam int          NEG_SPAN     = 16;
    localparam int          DELTA_LIMIT  = 500_000_000;
    localparam int          ACC_W        = 32;
    localparam logic [63:0] NOMINAL_PER  = 64'h1FF0_0000_0000_0000;

endpackage

// File: rtl/tod_period_reg.sv
// Per-domain period holder: a shadow register takes writes at any time and the
// active period copies it on the falling edge of the freeze bit.
// Assumes writes and freeze come from the same clock domain.
module tod_period_reg
    import tod_pkg::*;
#(
    parameter int PER_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frz_i,
    input  logic             wr_i,
    input  logic [PER_W-1:0] wdata_i,
    output logic [PER_W-1:0] per_o
);

    logic [PER_W-1:0] shadow_q;
    logic [PER_W-1:0] active_q;
    logic             frz_q;
    logic             commit;

    assign commit = frz_q && !frz_i;

    // Capture period writes into the shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= PER_W'(NOMINAL_PER);
        else if (wr_i) shadow_q <= wdata_i;
    end

    // Track freeze and commit the shadow when freeze is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_q    <= 1'b0;
            active_q <= PER_W'(NOMINAL_PER);
        end else begin
            frz_q <= frz_i;
            if (commit) active_q <= shadow_q;
        end
    end

    assign per_o = active_q;

    // R10: while frozen the active period cannot move at the next edge.
    p_frozen_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frz_i |=> $stable(per_o));

endmodule

// File: rtl/tod_dom_counter.sv
// One time-of-day domain: fractional accumulator, nanoseconds with the
// negative window encoding, and seconds. Load has priority over delta, and
// delta over the increment. Assumes NS_W is 30 and the delta input is 32 bits.
module tod_dom_counter
    import tod_pkg::*;
#(
    parameter int SEC_W  = 48,
    parameter int NS_W   = 30,
    parameter int PER_W  = 64,
    parameter int FRAC_W = 59
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena_i,
    input  logic [PER_W-1:0] per_i,
    input  logic             ld_i,
    input  logic [SEC_W-1:0] ld_sec_i,
    input  logic [NS_W-1:0]  ld_ns_i,
    input  logic             dlt_i,
    input  logic [ACC_W-1:0] dlt_val_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [NS_W-1:0]  ns_o
);

    localparam int INT_W = PER_W - FRAC_W;
    localparam int CW    = NS_W + 4;
    localparam logic signed [CW-1:0] SEC_S  = CW'(NS_PER_SEC);
    localparam logic signed [CW-1:0] WRAP_S = CW'(64'd1 << NS_W);
    localparam logic signed [CW-1:0] NEG_S  = -CW'(NEG_SPAN);
    localparam logic [NS_W-1:0]      NEG_LO = NS_W'((64'd1 << NS_W) - NEG_SPAN);

    logic [FRAC_W-1:0]     frac_q, frac_n;
    logic [NS_W-1:0]       ns_q, ns_n;
    logic [SEC_W-1:0]      sec_q, sec_n;
    logic [FRAC_W:0]       frac_sum;
    logic [INT_W:0]        step;
    logic signed [CW-1:0]  ns_s, ns_inc, ns_dlt;

    // Decode the stored nanoseconds into a signed value (window is negative).
    always_comb begin
        if (ns_q >= NEG_LO) ns_s = $signed({4'b0000, ns_q}) - WRAP_S;
        else                ns_s = $signed({4'b0000, ns_q});
    end

    // Fraction sum, whole-nanosecond step and candidate results.
    always_comb begin
        frac_sum = {1'b0, frac_q} + {1'b0, per_i[FRAC_W-1:0]};
        step     = {1'b0, per_i[PER_W-1:FRAC_W]} + (INT_W+1)'(frac_sum[FRAC_W]);
        ns_inc   = ns_s + $signed({{(CW-INT_W-1){1'b0}}, step});
        ns_dlt   = ns_s + $signed({{(CW-ACC_W){dlt_val_i[ACC_W-1]}}, dlt_val_i});
    end

    // Next-state selection: load, then delta, then increment, else hold.
    always_comb begin
        frac_n = frac_q;
        ns_n   = ns_q;
        sec_n  = sec_q;
        if (ld_i) begin
            frac_n = '0;
            ns_n   = ld_ns_i;
            sec_n  = ld_sec_i;
        end else if (dlt_i) begin
            if (ns_dlt >= SEC_S) begin
                ns_n  = NS_W'(ns_dlt - SEC_S);
                sec_n = sec_q + 1'b1;
            end else if (ns_dlt < NEG_S) begin
                ns_n  = NS_W'(ns_dlt + SEC_S);
                sec_n = sec_q - 1'b1;
            end else begin
                ns_n  = NS_W'(ns_dlt);
            end
        end else if (ena_i) begin
            frac_n = frac_sum[FRAC_W-1:0];
            if (ns_inc >= SEC_S) begin
                ns_n  = NS_W'(ns_inc - SEC_S);
                sec_n = sec_q + 1'b1;
            end else begin
                ns_n  = NS_W'(ns_inc);
            end
        end
    end

    // Domain state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_q <= '0;
            ns_q   <= '0;
            sec_q  <= '0;
        end else begin
            frac_q <= frac_n;
            ns_q   <= ns_n;
            sec_q  <= sec_n;
        end
    end

    assign sec_o = sec_q;
    assign ns_o  = ns_q;

    // R3: an idle, disabled domain keeps its time.
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ena_i && !ld_i && !dlt_i) |=> ($stable(sec_o) && $stable(ns_o)));

    // R4: counting moves the seconds by zero or one.
    p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_i && !ld_i && !dlt_i) |=>
            (sec_o == $past(sec_o) || sec_o == $past(sec_o) + 1'b1));

    // R5: a load shows the loaded time after the edge.
    p_load_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (ns_o == $past(ld_ns_i) && sec_o == $past(ld_sec_i)));

    // R7: a delta moves the seconds by at most one.
    p_delta_sec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dlt_i && !ld_i) |=> (sec_o == $past(sec_o) ||
                              sec_o == $past(sec_o) + 1'b1 ||
                              sec_o == $past(sec_o) - 1'b1));

endmodule

// File: rtl/tod_access.sv
// Access port: holds the seconds and nanosecond access registers, remembers
// the previous action code, and turns a change of code into one strobe for the
// selected domain. Assumes domain times arrive as packed per-domain arrays.
module tod_access
    import tod_pkg::*;
#(
    parameter int NUM_DOM = 3,
    parameter int SEC_W   = 48,
    parameter int NS_W    = 30,
    parameter int DOM_W   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   act_i,
    input  logic [DOM_W-1:0]             dom_i,
    input  logic                         wr_i,
    input  logic [1:0]                   wsel_i,
    input  logic [ACC_W-1:0]             wdata_i,
    input  logic [NUM_DOM-1:0][SEC_W-1:0] dom_sec_i,
    input  logic [NUM_DOM-1:0][NS_W-1:0]  dom_ns_i,
    output logic [NUM_DOM-1:0]           ld_o,
    output logic [NUM_DOM-1:0]           dlt_o,
    output logic                         save_o,
    output logic [SEC_W-1:0]             acc_sec_o,
    output logic [ACC_W-1:0]             acc_ns_o
);

    localparam int HI_W = SEC_W - 32;

    tod_act_e          act, act_q;
    logic              fire, dom_ok, in_range;
    logic              ld_fire, sv_fire, dl_fire;
    logic [SEC_W-1:0]  sel_sec, acc_sec_q;
    logic [NS_W-1:0]   sel_ns;
    logic [ACC_W-1:0]  acc_ns_q;
    logic              unused_wdata_hi;

    assign act             = tod_act_e'(act_i);
    assign unused_wdata_hi = ^wdata_i[ACC_W-1:HI_W];

    // Decode the action edge, domain validity and delta range.
    always_comb begin
        fire     = (act != act_q);
        dom_ok   = (int'(dom_i) < NUM_DOM);
        in_range = ($signed(acc_ns_q) < $signed(ACC_W'(DELTA_LIMIT))) &&
                   ($signed(acc_ns_q) > -$signed(ACC_W'(DELTA_LIMIT)));
        ld_fire  = fire && dom_ok && act == ACT_LOAD && act_q == ACT_IDLE;
        sv_fire  = fire && dom_ok && act == ACT_SAVE;
        dl_fire  = fire && dom_ok && act == ACT_DELTA && in_range;
    end

    // Per-domain strobes.
    generate
        for (genvar d = 0; d < NUM_DOM; d++) begin : g_strobe
            assign ld_o[d]  = ld_fire && (int'(dom_i) == d);
            assign dlt_o[d] = dl_fire && (int'(dom_i) == d);
        end
    endgenerate
    assign save_o = sv_fire;

    // Select the time of the addressed domain for a snapshot.
    always_comb begin
        sel_sec = '0;
        sel_ns  = '0;
        for (int d = 0; d < NUM_DOM; d++) begin
            if (int'(dom_i) == d) begin
                sel_sec = dom_sec_i[d];
                sel_ns  = dom_ns_i[d];
            end
        end
    end

    // Remember the last action code.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= ACT_IDLE;
        else        act_q <= act;
    end

    // Access registers: snapshot wins over a software write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_sec_q <= '0;
            acc_ns_q  <= '0;
        end else if (sv_fire) begin
            acc_sec_q <= sel_sec;
            acc_ns_q  <= ACC_W'(sel_ns);
        end else if (wr_i) begin
            case (wsel_i)
                2'd0:    acc_ns_q         <= wdata_i;
                2'd1:    acc_sec_q[31:0]  <= wdata_i;
                2'd2:    acc_sec_q[SEC_W-1:32] <= wdata_i[HI_W-1:0];
                default: ;
            endcase
        end
    end

    assign acc_sec_o = acc_sec_q;
    assign acc_ns_o  = acc_ns_q;

    // R6: a snapshot holds the addressed domain's pre-edge time.
    p_save_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        save_o |=> (acc_ns_o == ACC_W'($past(sel_ns)) && acc_sec_o == $past(sel_sec)));

endmodule

// File: rtl/tod_multi_domain.sv
// Top of the multi-domain time-of-day counter: one period holder and one
// counter per domain, plus the shared access port. Outputs are flattened with
// domain d at slice d. Assumes one clock for all logic.
module tod_multi_domain
    import tod_pkg::*;
#(
    parameter int NUM_DOM = 3,
    parameter int SEC_W   = 48,
    parameter int NS_W    = 30,
    parameter int PER_W   = 64,
    parameter int FRAC_W  = 59,
    parameter int DOM_W   = $clog2(NUM_DOM + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_DOM-1:0]       dom_ena_i,
    input  logic [NUM_DOM-1:0]       per_frz_i,
    input  logic                     per_wr_i,
    input  logic [DOM_W-1:0]         per_dom_i,
    input  logic [PER_W-1:0]         per_wdata_i,
    input  logic [2:0]               acc_act_i,
    input  logic [DOM_W-1:0]         acc_dom_i,
    input  logic                     acc_wr_i,
    input  logic [1:0]               acc_wsel_i,
    input  logic [31:0]              acc_wdata_i,
    output logic [SEC_W-1:0]         acc_sec_o,
    output logic [31:0]              acc_ns_o,
    output logic [NUM_DOM*SEC_W-1:0] tod_sec_o,
    output logic [NUM_DOM*NS_W-1:0]  tod_ns_o
);

    logic [NUM_DOM-1:0][SEC_W-1:0] dom_sec;
    logic [NUM_DOM-1:0][NS_W-1:0]  dom_ns;
    logic [NUM_DOM-1:0]            ld, dlt;
    logic                          save;

    tod_access #(
        .NUM_DOM (NUM_DOM),
        .SEC_W   (SEC_W),
        .NS_W    (NS_W),
        .DOM_W   (DOM_W)
    ) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (acc_act_i),
        .dom_i     (acc_dom_i),
        .wr_i      (acc_wr_i),
        .wsel_i    (acc_wsel_i),
        .wdata_i   (acc_wdata_i),
        .dom_sec_i (dom_sec),
        .dom_ns_i  (dom_ns),
        .ld_o      (ld),
        .dlt_o     (dlt),
        .save_o    (save),
        .acc_sec_o (acc_sec_o),
        .acc_ns_o  (acc_ns_o)
    );

    generate
        for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
            logic [PER_W-1:0] per;

            tod_period_reg #(.PER_W(PER_W)) u_per (
                .clk     (clk),
                .rst_n   (rst_n),
                .frz_i   (per_frz_i[d]),
                .wr_i    (per_wr_i && (int'(per_dom_i) == d)),
                .wdata_i (per_wdata_i),
                .per_o   (per)
            );

            tod_dom_counter #(
                .SEC_W  (SEC_W),
                .NS_W   (NS_W),
                .PER_W  (PER_W),
                .FRAC_W (FRAC_W)
            ) u_ctr (
                .clk       (clk),
                .rst_n     (rst_n),
                .ena_i     (dom_ena_i[d]),
                .per_i     (per),
                .ld_i      (ld[d]),
                .ld_sec_i  (acc_sec_o),
                .ld_ns_i   (acc_ns_o[NS_W-1:0]),
                .dlt_i     (dlt[d]),
                .dlt_val_i (acc_ns_o),
                .sec_o     (dom_sec[d]),
                .ns_o      (dom_ns[d])
            );

            assign tod_sec_o[d*SEC_W +: SEC_W] = dom_sec[d];
            assign tod_ns_o[d*NS_W +: NS_W]    = dom_ns[d];
        end
    endgenerate

    // R9: one code change yields at most one action on at most one domain.
    p_single_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld, dlt, save}));

    // R9: holding a code fires nothing on the following edge.
    p_no_refire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|{ld, dlt, save}) |=> ($stable(acc_act_i) -> !(|{ld, dlt, save})));

endmodule

// File: tb/sim_tod_multi_domain.sv
// Directed bench for the multi-domain time-of-day counter.
module sim_tod_multi_domain;

    localparam int ND = 3;
    localparam int SW = 48;
    localparam int NW = 30;
    localparam int DW = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [ND-1:0]      dom_ena = '0;
    logic [ND-1:0]      per_frz = '0;
    logic               per_wr = 1'b0;
    logic [DW-1:0]      per_dom = '0;
    logic [63:0]        per_wdata = '0;
    logic [2:0]         acc_act = 3'd0;
    logic [DW-1:0]      acc_dom = '0;
    logic               acc_wr = 1'b0;
    logic [1:0]         acc_wsel = '0;
    logic [31:0]        acc_wdata = '0;
    logic [SW-1:0]      acc_sec;
    logic [31:0]        acc_ns;
    logic [ND*SW-1:0]   tod_sec;
    logic [ND*NW-1:0]   tod_ns;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tod_multi_domain u0 (
        .clk(clk), .rst_n(rst_n), .dom_ena_i(dom_ena), .per_frz_i(per_frz),
        .per_wr_i(per_wr), .per_dom_i(per_dom), .per_wdata_i(per_wdata),
        .acc_act_i(acc_act), .acc_dom_i(acc_dom), .acc_wr_i(acc_wr),
        .acc_wsel_i(acc_wsel), .acc_wdata_i(acc_wdata),
        .acc_sec_o(acc_sec), .acc_ns_o(acc_ns), .tod_sec_o(tod_sec), .tod_ns_o(tod_ns)
    );

    function automatic logic [63:0] ns_of(int d);
        return 64'(tod_ns[d*NW +: NW]);
    endfunction
    function automatic logic [63:0] sec_of(int d);
        return 64'(tod_sec[d*SW +: SW]);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic acc_write(input logic [1:0] sel, input logic [31:0] val);
        acc_wr = 1'b1; acc_wsel = sel; acc_wdata = val;
        step(1);
        acc_wr = 1'b0;
    endtask

    task automatic per_write(input int d, input logic [63:0] val);
        per_wr = 1'b1; per_dom = DW'(d); per_wdata = val;
        step(1);
        per_wr = 1'b0;
    endtask

    task automatic fire(input logic [2:0] code, input int d);
        acc_dom = DW'(d); acc_act = code;
        step(1);
        acc_act = 3'd0;
        step(1);
    endtask

    task automatic apply_delta(input int d, input logic [31:0] val);
        acc_write(2'd0, val);
        fire(3'd4, d);
    endtask

    // R1: reset values.
    task automatic t_reset();
        for (int d = 0; d < ND; d++) begin
            chk("R1 ns", ns_of(d), 0);
            chk("R1 sec", sec_of(d), 0);
        end
        chk("R1 acc_ns", 64'(acc_ns), 0);
        chk("R1 acc_sec", 64'(acc_sec), 0);
    endtask

    // R2, R3: nominal fractional rate, then hold while disabled.
    task automatic t_nominal();
        logic [63:0] held;
        dom_ena[0] = 1'b1;
        step(100);
        dom_ena[0] = 1'b0;
        chk("R2 nominal rate", ns_of(0), (100 * 511) / 128);
        held = ns_of(0);
        step(1);
        held = ns_of(0);
        step(5);
        chk("R3 disabled hold", ns_of(0), held);
        chk("R3 other domain idle", ns_of(1), 0);
    endtask

    // R10: frozen period write commits on release; later write without freeze is ignored.
    task automatic t_period();
        per_frz[1] = 1'b1;
        step(1);
        per_write(1, 64'h4000_0000_0000_0000);
        per_frz[1] = 1'b0;
        step(1);
        dom_ena[1] = 1'b1;
        step(10);
        chk("R10 committed 8ns rate", ns_of(1), 80);
        per_write(1, 64'h8000_0000_0000_0000);
        step(9);
        chk("R10 unfrozen write ignored", ns_of(1), 160);
    endtask

    // R11, R5, R4, R9, R6: access writes, load, rollover, snapshot, ignored load.
    task automatic t_load_save();
        logic [63:0] x_ns, x_sec, y_ns;
        acc_write(2'd0, 32'd999_999_990);
        acc_write(2'd1, 32'd5);
        acc_write(2'd2, 32'hFFFF_0001);
        chk("R11 ns word", 64'(acc_ns), 999_999_990);
        chk("R11 sec words", 64'(acc_sec), 64'h1_0000_0005);
        acc_dom = 2'd1; acc_act = 3'd1;
        step(1);
        chk("R5 load ns", ns_of(1), 999_999_990);
        chk("R5 load sec", sec_of(1), 64'h1_0000_0005);
        step(1);
        chk("R9 held LOAD no refire", ns_of(1), 999_999_998);
        step(1);
        chk("R4 rollover ns", ns_of(1), 6);
        chk("R4 rollover sec", sec_of(1), 64'h1_0000_0006);
        acc_act = 3'd0;
        step(1);
        x_ns = ns_of(1); x_sec = sec_of(1);
        acc_act = 3'd2;
        step(1);
        chk("R6 save ns", 64'(acc_ns), x_ns);
        chk("R6 save sec", 64'(acc_sec), x_sec);
        y_ns = ns_of(1);
        acc_act = 3'd1;
        step(1);
        chk("R5 load from SAVE ignored", ns_of(1), y_ns + 8);
        acc_act = 3'd0;
        dom_ena[1] = 1'b0;
        step(1);
    endtask

    // R7, R8: delta arithmetic, negative window, counting through zero.
    task automatic t_delta();
        per_frz[2] = 1'b1;
        step(1);
        per_write(2, 64'h2000_0000_0000_0000);
        per_frz[2] = 1'b0;
        step(1);
        acc_write(2'd0, 32'd5);
        acc_write(2'd1, 32'd10);
        acc_write(2'd2, 32'd0);
        fire(3'd1, 2);
        chk("R5 load dom2", ns_of(2), 5);
        apply_delta(2, -32'sd3);
        chk("R7 small negative delta", ns_of(2), 2);
        apply_delta(2, -32'sd10);
        chk("R8 window ns", ns_of(2), 64'h3FFF_FFF8);
        chk("R8 window sec", sec_of(2), 10);
        dom_ena[2] = 1'b1;
        step(3);
        dom_ena[2] = 1'b0;
        chk("R8 count through zero ns", ns_of(2), 4);
        chk("R8 count through zero sec", sec_of(2), 10);
        step(1);
        apply_delta(2, -32'sd20);
        chk("R8 window low edge", ns_of(2), 64'h3FFF_FFF0);
        apply_delta(2, -32'sd1);
        chk("R8 borrow ns", ns_of(2), 999_999_983);
        chk("R8 borrow sec", sec_of(2), 9);
        apply_delta(2, 32'd17);
        chk("R7 carry ns", ns_of(2), 0);
        chk("R7 carry sec", sec_of(2), 10);
        apply_delta(2, 32'd500_000_000);
        chk("R7 large positive ignored", ns_of(2), 0);
        apply_delta(2, -32'sd500_000_000);
        chk("R7 large negative ignored", ns_of(2), 0);
        chk("R7 large ignored sec", sec_of(2), 10);
    endtask

    // R9: reserved codes and out-of-range domain do nothing.
    task automatic t_noop();
        logic [63:0] n0, n1, n2, s2, a_ns, a_sec;
        acc_write(2'd0, 32'd123);
        n0 = ns_of(0); n1 = ns_of(1); n2 = ns_of(2); s2 = sec_of(2);
        a_ns = 64'(acc_ns); a_sec = 64'(acc_sec);
        fire(3'd3, 2);
        chk("R9 code 3 dom", ns_of(2), n2);
        chk("R9 code 3 acc", 64'(acc_ns), a_ns);
        fire(3'd5, 2);
        chk("R9 code 5 dom", ns_of(2), n2);
        chk("R9 code 5 acc sec", 64'(acc_sec), a_sec);
        fire(3'd1, 3);
        chk("R9 bad domain d0", ns_of(0), n0);
        chk("R9 bad domain d1", ns_of(1), n1);
        chk("R9 bad domain d2", ns_of(2), n2);
        chk("R9 bad domain d2 sec", sec_of(2), s2);
    endtask

    initial begin : watchdog
        repeat (100_000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_nominal();
        t_period();
        t_load_save();
        t_delta();
        t_noop();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule